// File: doc/BRIEF.md
# Serial-Clock Wiper Stepper

This block moves one of several digital potentiometer wiper codes up or down, one position at a time, using the two-wire serial bus clock as its step clock. The command decoder arms the block with a one-cycle mode pulse after it has acknowledged the step instruction byte. The pulse carries the wiper selection. From then on, every rising edge of the filtered serial clock moves the chosen wiper by one position. The serial data level sampled at that edge sets the direction: high moves the code up, toward the high terminal, and low moves it down, toward the low terminal.

A sequence may mix any number of up and down steps. It ends when a STOP or a new START is detected, and the block then ignores the clock until it is armed again. Codes stop at their ends and never wrap. The block keeps the wiper codes as volatile registers and reports each applied step as a one-cycle up or down pulse with the index of the wiper that moved.

Top module: `wiper_step_ctrl`

## Requirements
- R1: After reset, every wiper code equals INIT_CODE (0x80 by default). Step mode is inactive, and both step pulses are low.
- R2: A mode pulse on `step_arm` activates step mode and latches `sel_in`. Only the wiper selected by that value changes during the sequence.
- R3: While step mode is active, an SCL rising edge with SDA high raises the selected code by one. One clock later, `step_up` is high for exactly one cycle and `step_idx` shows the selected wiper.
- R4: While step mode is active, an SCL rising edge with SDA low lowers the selected code by one. One clock later, `step_dn` is high for exactly one cycle and `step_idx` shows the selected wiper.
- R5: A code of 0xFF is unchanged by an up step, and no `step_up` pulse is given.
- R6: A code of 0x00 is unchanged by a down step, and no `step_dn` pulse is given.
- R7: A `stop_det` pulse ends step mode. Later SCL edges change no code.
- R8: A `start_det` pulse ends step mode. Later SCL edges change no code.
- R9: SCL edges while step mode is inactive change no code.
- R10: Exactly one step is applied per SCL rising edge. Holding SCL high and letting it fall cause no further step.
- R11: An SCL rising edge seen in the same cycle as a START or STOP indication is not applied as a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_lvl | input | 1 | Filtered serial clock level |
| sda_lvl | input | 1 | Filtered serial data level |
| start_det | input | 1 | One-cycle START indication |
| stop_det | input | 1 | One-cycle STOP indication |
| step_arm | input | 1 | One-cycle pulse that enters step mode |
| sel_in | input | SEL_W | Wiper selection, latched on `step_arm` |
| step_active | output | 1 | Step mode in progress |
| step_up | output | 1 | One-cycle pulse for an applied up step |
| step_dn | output | 1 | One-cycle pulse for an applied down step |
| step_idx | output | SEL_W | Index of the wiper that was stepped |
| wiper_codes | output | NUM_WIPERS*CODE_W | All wiper codes, wiper 0 in the least significant field |

## Verification
The assertions assume that `start_det` and `stop_det` are single-cycle pulses from a bus monitor. They also assume that SCL and SDA are already synchronised and filtered, so that one SCL high phase is a single rising edge at the system clock. The bench drives every input on the falling edge of the system clock. It holds each SCL level for several system cycles and changes SDA only while SCL is low, except when it builds a START or STOP next to an SCL edge on purpose. Each wiper is swept from the reset code to both limits and past them.

// File: rtl/wstep_pkg.sv
package wstep_pkg;
  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DN   = 2'd2
  } step_dir_e;
endpackage

// File: rtl/wstep_edge.sv
module wstep_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_lvl,
  output logic scl_rise
);
  logic scl_q;

  // Resets high so that an idle-high bus never shows a false edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scl_q <= 1'b1;
    else        scl_q <= scl_lvl;
  end

  assign scl_rise = scl_lvl & ~scl_q;
endmodule

// File: rtl/wstep_mode.sv
module wstep_mode #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [SEL_W-1:0] sel_in,
  input  logic             start_det,
  input  logic             stop_det,
  output logic             active,
  output logic [SEL_W-1:0] sel_q
);
  logic bus_break;
  assign bus_break = start_det | stop_det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      sel_q  <= '0;
    end else begin
      if (bus_break)  active <= 1'b0;
      else if (arm)   active <= 1'b1;
      if (arm)        sel_q  <= sel_in;
    end
  end
endmodule

// File: rtl/wstep_bank.sv
module wstep_bank
  import wstep_pkg::*;
#(
  parameter int               NUM_WIPERS = 4,
  parameter int               CODE_W     = 8,
  parameter logic [CODE_W-1:0] INIT_CODE = 8'h80,
  localparam int              SEL_W      = $clog2(NUM_WIPERS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         step_go,
  input  step_dir_e                    dir,
  input  logic [SEL_W-1:0]             sel,
  output logic [NUM_WIPERS*CODE_W-1:0] codes,
  output logic                         up_pulse,
  output logic                         dn_pulse,
  output logic [SEL_W-1:0]             idx
);
  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_MIN = '0;

  function automatic logic [CODE_W-1:0] sat_up(input logic [CODE_W-1:0] c);
    return (c == CODE_MAX) ? c : c + 1'b1;
  endfunction

  function automatic logic [CODE_W-1:0] sat_dn(input logic [CODE_W-1:0] c);
    return (c == CODE_MIN) ? c : c - 1'b1;
  endfunction

  logic [CODE_W-1:0] cur;
  logic              up_ok, dn_ok;

  assign cur   = codes[sel*CODE_W +: CODE_W];
  assign up_ok = step_go && (dir == DIR_UP) && (cur != CODE_MAX);
  assign dn_ok = step_go && (dir == DIR_DN) && (cur != CODE_MIN);

  for (genvar w = 0; w < NUM_WIPERS; w++) begin : g_wiper
    logic hit;
    assign hit = (sel == SEL_W'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        codes[w*CODE_W +: CODE_W] <= INIT_CODE;
      else if (hit && up_ok)
        codes[w*CODE_W +: CODE_W] <= sat_up(codes[w*CODE_W +: CODE_W]);
      else if (hit && dn_ok)
        codes[w*CODE_W +: CODE_W] <= sat_dn(codes[w*CODE_W +: CODE_W]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_pulse <= 1'b0;
      dn_pulse <= 1'b0;
      idx      <= '0;
    end else begin
      up_pulse <= up_ok;
      dn_pulse <= dn_ok;
      if (up_ok || dn_ok) idx <= sel;
    end
  end
endmodule

// File: rtl/wiper_step_ctrl.sv
module wiper_step_ctrl
  import wstep_pkg::*;
#(
  parameter int               NUM_WIPERS = 4,
  parameter int               CODE_W     = 8,
  parameter logic [CODE_W-1:0] INIT_CODE = 8'h80,
  localparam int              SEL_W      = $clog2(NUM_WIPERS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         scl_lvl,
  input  logic                         sda_lvl,
  input  logic                         start_det,
  input  logic                         stop_det,
  input  logic                         step_arm,
  input  logic [SEL_W-1:0]             sel_in,
  output logic                         step_active,
  output logic                         step_up,
  output logic                         step_dn,
  output logic [SEL_W-1:0]             step_idx,
  output logic [NUM_WIPERS*CODE_W-1:0] wiper_codes
);
  logic             scl_rise;
  logic [SEL_W-1:0] sel_q;
  logic             step_go;
  step_dir_e        dir;

  wstep_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_lvl  (scl_lvl),
    .scl_rise (scl_rise)
  );

  wstep_mode #(.SEL_W(SEL_W)) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (step_arm),
    .sel_in    (sel_in),
    .start_det (start_det),
    .stop_det  (stop_det),
    .active    (step_active),
    .sel_q     (sel_q)
  );

  // A bus condition in the same cycle as an edge wins over the step.
  assign step_go = step_active && scl_rise && !start_det && !stop_det;
  assign dir     = sda_lvl ? DIR_UP : DIR_DN;

  wstep_bank #(
    .NUM_WIPERS (NUM_WIPERS),
    .CODE_W     (CODE_W),
    .INIT_CODE  (INIT_CODE)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_go  (step_go),
    .dir      (dir),
    .sel      (sel_q),
    .codes    (wiper_codes),
    .up_pulse (step_up),
    .dn_pulse (step_dn),
    .idx      (step_idx)
  );
endmodule

// File: rtl/wstep_checker.sv
module wstep_checker #(
  parameter int NUM_WIPERS = 4,
  parameter int CODE_W     = 8,
  localparam int SEL_W     = $clog2(NUM_WIPERS)
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         start_det,
  input logic                         stop_det,
  input logic                         step_active,
  input logic                         step_up,
  input logic                         step_dn,
  input logic [SEL_W-1:0]             step_idx,
  input logic [NUM_WIPERS*CODE_W-1:0] wiper_codes
);
  logic [NUM_WIPERS*CODE_W-1:0] prev_codes;
  logic [CODE_W-1:0]            cur_sel, prev_sel;

  always_ff @(posedge clk) prev_codes <= wiper_codes;

  assign cur_sel  = wiper_codes[step_idx*CODE_W +: CODE_W];
  assign prev_sel = prev_codes[step_idx*CODE_W +: CODE_W];

  // R3
  a_r3_up_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    step_up |-> (cur_sel == prev_sel + 1'b1));
  // R4
  a_r4_dn_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    step_dn |-> (cur_sel == prev_sel - 1'b1));
  // R10
  a_r10_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({step_up, step_dn}));
  // R7
  a_r7_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !step_active);
  // R8
  a_r8_start_ends: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !step_active);
  // R9
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step_active |=> $stable(wiper_codes));
endmodule

bind wiper_step_ctrl wstep_checker #(
  .NUM_WIPERS (NUM_WIPERS),
  .CODE_W     (CODE_W)
) chk_i (.*);

// File: tb/wiper_step_ctrl_tb_top.sv
module wiper_step_ctrl_tb_top;
  localparam int NW = 4;
  localparam int CW = 8;
  localparam int SW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, sta = 1'b0, sto = 1'b0, arm = 1'b0;
  logic [SW-1:0] sel = '0;
  logic active, up, dn;
  logic [SW-1:0] idx;
  logic [NW*CW-1:0] codes;

  int n_tests = 0;
  int n_fail  = 0;
  int expc [NW];

  always #2.5 clk = ~clk;

  wiper_step_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl), .sda_lvl(sda),
    .start_det(sta), .stop_det(sto), .step_arm(arm), .sel_in(sel),
    .step_active(active), .step_up(up), .step_dn(dn),
    .step_idx(idx), .wiper_codes(codes)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    for (int w = 0; w < NW; w++)
      chk(req, int'(codes[w*CW +: CW]), expc[w]);
  endtask

  task automatic do_arm(input int s);
    @(negedge clk); sel = SW'(s); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
    chk("R2 active", int'(active), 1);
  endtask

  task automatic bus_cond(input bit is_stop);
    @(negedge clk); if (is_stop) sto = 1'b1; else sta = 1'b1;
    @(negedge clk); sto = 1'b0; sta = 1'b0;
    chk(is_stop ? "R7 inactive" : "R8 inactive", int'(active), 0);
  endtask

  // One SCL pulse; applies a step to expc when 'live' and checks the result.
  task automatic scl_pulse(input bit dir_up, input bit live, input int w, input string req);
    bit moved;
    @(negedge clk); sda = dir_up;
    @(negedge clk); scl = 1'b1;
    moved = 1'b0;
    if (live) begin
      if (dir_up && expc[w] < 255) begin expc[w]++; moved = 1'b1; end
      if (!dir_up && expc[w] > 0)  begin expc[w]--; moved = 1'b1; end
    end
    @(negedge clk);
    chk({req, " up pulse"}, int'(up), int'(moved && dir_up));
    chk({req, " dn pulse"}, int'(dn), int'(moved && !dir_up));
    if (moved) chk({req, " idx"}, int'(idx), w);
    chk_all(req);
    @(negedge clk);
    chk("R10 held high no pulse", int'(up | dn), 0);
    scl = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R10 fall no step", int'(up | dn), 0);
    chk_all("R10");
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int w = 0; w < NW; w++) expc[w] = 128;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 init code");
    chk("R1 inactive", int'(active), 0);
    chk("R1 pulses", int'(up | dn), 0);
    scl = 1'b0;

    // R9: edges before arming
    scl_pulse(1'b1, 1'b0, 0, "R9 unarmed up");
    scl_pulse(1'b0, 1'b0, 0, "R9 unarmed dn");

    // Sweep each wiper to both limits (R2, R3, R4, R5, R6)
    for (int w = 0; w < NW; w++) begin
      do_arm(w);
      for (int k = 0; k < 130; k++) scl_pulse(1'b1, 1'b1, w, "R3 R5 up sweep");
      chk("R5 at max", expc[w], 255);
      for (int k = 0; k < 258; k++) scl_pulse(1'b0, 1'b1, w, "R4 R6 dn sweep");
      chk("R6 at min", expc[w], 0);
      for (int k = 0; k < 5; k++) scl_pulse(k[0], 1'b1, w, "R2 mixed");
      bus_cond(w[0]);
      scl_pulse(1'b1, 1'b0, w, w[0] ? "R7 after stop" : "R8 after start");
    end

    // R11: edge coinciding with STOP, then with START
    do_arm(2);
    @(negedge clk); sda = 1'b1;
    @(negedge clk); scl = 1'b1; sto = 1'b1;
    @(negedge clk); sto = 1'b0;
    chk("R11 stop edge no pulse", int'(up | dn), 0);
    chk("R11 stop ends", int'(active), 0);
    chk_all("R11 stop");
    @(negedge clk); scl = 1'b0;
    do_arm(3);
    @(negedge clk); sda = 1'b0;
    @(negedge clk); scl = 1'b1; sta = 1'b1;
    @(negedge clk); sta = 1'b0;
    chk("R11 start edge no pulse", int'(up | dn), 0);
    chk_all("R11 start");
    @(negedge clk); scl = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule